// File: doc/BRIEF.md
# Serially Programmed Clock Fanout Controller

This block holds the configuration logic of a clock fanout buffer with ten outputs and two candidate input clocks. A control clock and a serial data pin load an eleven-bit configuration word, one bit per control-clock edge. One further edge copies the word into a control register. That register holds one enable bit per output and one bit that selects the input clock. After the commit the loader locks. It ignores further control-clock edges until it is reset.

A mode pin chooses between two behaviours. With the mode pin high, the block is in programmed mode: it loads the word and the committed control register drives the outputs. With the mode pin low, the block is in fixed mode: every output is enabled, the serial pin selects the input clock directly, and any control-clock edge returns the loader to its start. Each output is presented as a data bit that carries the selected clock, together with an output-enable bit. A low enable bit stands for an undriven output.

The sequencer has four states:
- IDLE: nothing shifted yet.
- SHIFT: one to ten bits taken.
- COMMIT: eleven bits taken.
- LOCKED: the word has been committed.

The transitions are:
- IDLE to SHIFT on the first shift.
- SHIFT to COMMIT on the eleventh shift.
- COMMIT to LOCKED on the commit edge.
- Any state back to IDLE on an edge with the mode pin low, or on the asynchronous reset.

Top module: `fanout_cfg_ctrl`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, the control register is all zero. With `en` high, every `q_oe` bit is 0 and every `q_data` bit equals `clk_in0`.
- R2: While `en` is high and the loader is in IDLE or SHIFT, each rising `ck` edge shifts `si` in. After exactly eleven such edges the outputs are still unchanged. The twelfth edge commits the word to the control register.
- R3: Bit order of the word: the first bit shifted in is the enable for output 9, the second for output 8, and so on, so the tenth is the enable for output 0. The eleventh bit is the clock select.
- R4: In programmed mode, a committed select of 0 drives every `q_data` bit from `clk_in0` and a select of 1 drives it from `clk_in1`. This holds whatever the enable bits are.
- R5: In programmed mode, `q_oe[k]` equals the committed enable bit for output k. A 1 means driven and a 0 means open.
- R6: A rising `ck` edge with `en` low clears the sequencer, the shift register and the control register to the reset state.
- R7: Once committed (LOCKED), further `ck` edges with `en` high have no effect on `q_oe` or on the clock selection.
- R8: With `en` low, all `q_oe` bits are 1, and `si` selects `clk_in0` (0) or `clk_in1` (1) without any `ck` edge.
- R9: A partial load that is ended by an `en`-low edge is discarded. The next load starts again at the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ck | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Mode: 1 programmed, 0 fixed |
| si | input | 1 | Serial configuration data, or direct clock select in fixed mode |
| clk_in0 | input | 1 | Input clock 0 |
| clk_in1 | input | 1 | Input clock 1 |
| q_data | output | NUM_OUT | Selected clock for each output |
| q_oe | output | NUM_OUT | Output enable for each output; 0 means open |

## Verification
The bench builds the block with the default `NUM_OUT` of 10, so the word is eleven bits long and the counter is four bits wide. With this size the bench can reach:
- the exact eleventh-shift and twelfth-commit boundary,
- words whose enable patterns have the first-sent and last-sent bits distinct,
- both select values,
- locking after the commit,
- a load aborted after a few bits.

The input clocks are driven as static opposite levels, so which input the data bits carry can be told from their value.

// File: rtl/fanout_cfg_pkg.sv
package fanout_cfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_LOCKED
    } seq_state_t;
endpackage

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import fanout_cfg_pkg::*;
#(
    parameter int CFG_BITS = 11,
    parameter int CNT_W    = 4
) (
    input  logic ck,
    input  logic rst_n,
    input  logic en,
    output logic shift_en,
    output logic commit_en,
    output logic clr
);
    seq_state_t         state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n;

    // state register and clock counter
    always_ff @(posedge ck or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (!en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SHIFT: begin
                    cnt_n   = cnt + 1'b1;
                    state_n = (cnt_n == CNT_W'(CFG_BITS)) ? ST_COMMIT : ST_SHIFT;
                end
                ST_COMMIT: begin
                    cnt_n   = cnt + 1'b1;
                    state_n = ST_LOCKED;
                end
                ST_LOCKED: begin
                    cnt_n   = cnt;
                    state_n = ST_LOCKED;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_en  = 1'b0;
        commit_en = 1'b0;
        clr       = !en;
        unique case (state)
            ST_IDLE, ST_SHIFT: shift_en  = en;
            ST_COMMIT:         commit_en = en;
            ST_LOCKED:         ;
        endcase
    end

    // R7
    locked_hold_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (state == ST_LOCKED && en) |=> state == ST_LOCKED);
    // R2
    commit_count_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (state == ST_COMMIT) |-> cnt == CNT_W'(CFG_BITS));
    // R6
    clear_to_idle_chk: assert property (@(posedge ck) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && cnt == '0));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
    parameter int NUM_OUT  = 10,
    parameter int CFG_BITS = NUM_OUT + 1
) (
    input  logic               ck,
    input  logic               rst_n,
    input  logic               si,
    input  logic               shift_en,
    input  logic               commit_en,
    input  logic               clr,
    output logic [NUM_OUT-1:0] cfg_oe,
    output logic               cfg_sel
);
    logic [CFG_BITS-1:0] sr;
    logic [CFG_BITS-1:0] ctrl;

    always_ff @(posedge ck or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            ctrl <= '0;
        end else if (clr) begin
            sr   <= '0;
            ctrl <= '0;
        end else begin
            if (shift_en)  sr   <= {sr[CFG_BITS-2:0], si};
            if (commit_en) ctrl <= sr;
        end
    end

    // newest bit (last shifted) sits in bit 0 and is the select;
    // the first bit shifted ends in the top position, enabling the top output
    assign cfg_sel = ctrl[0];
    assign cfg_oe  = ctrl[CFG_BITS-1:1];

    // R7
    ctrl_frozen_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (!commit_en && !clr) |=> $stable(ctrl));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int NUM_OUT = 10
) (
    input  logic               en,
    input  logic               si,
    input  logic               clk_in0,
    input  logic               clk_in1,
    input  logic [NUM_OUT-1:0] cfg_oe,
    input  logic               cfg_sel,
    output logic [NUM_OUT-1:0] q_data,
    output logic [NUM_OUT-1:0] q_oe
);
    logic sel;
    logic clk_sel;

    assign sel     = en ? cfg_sel : si;
    assign clk_sel = sel ? clk_in1 : clk_in0;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign q_data[k] = clk_sel;
        assign q_oe[k]   = en ? cfg_oe[k] : 1'b1;
    end
endmodule

// File: rtl/fanout_cfg_ctrl.sv
module fanout_cfg_ctrl #(
    parameter int NUM_OUT = 10
) (
    input  logic               ck,
    input  logic               rst_n,
    input  logic               en,
    input  logic               si,
    input  logic               clk_in0,
    input  logic               clk_in1,
    output logic [NUM_OUT-1:0] q_data,
    output logic [NUM_OUT-1:0] q_oe
);
    localparam int CFG_BITS = NUM_OUT + 1;
    localparam int CNT_W    = $clog2(CFG_BITS + 2);

    logic               shift_en, commit_en, clr;
    logic [NUM_OUT-1:0] cfg_oe;
    logic               cfg_sel;

    cfg_sequencer #(.CFG_BITS(CFG_BITS), .CNT_W(CNT_W)) i_seq (
        .ck(ck), .rst_n(rst_n), .en(en),
        .shift_en(shift_en), .commit_en(commit_en), .clr(clr)
    );

    cfg_regs #(.NUM_OUT(NUM_OUT), .CFG_BITS(CFG_BITS)) i_regs (
        .ck(ck), .rst_n(rst_n), .si(si),
        .shift_en(shift_en), .commit_en(commit_en), .clr(clr),
        .cfg_oe(cfg_oe), .cfg_sel(cfg_sel)
    );

    out_stage #(.NUM_OUT(NUM_OUT)) i_out (
        .en(en), .si(si), .clk_in0(clk_in0), .clk_in1(clk_in1),
        .cfg_oe(cfg_oe), .cfg_sel(cfg_sel),
        .q_data(q_data), .q_oe(q_oe)
    );

    // R8
    fixed_all_on_chk: assert property (@(posedge ck) disable iff (!rst_n)
        !en |-> &q_oe);
    // R6
    cleared_after_en_low_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (!en ##1 en) |-> (q_oe == '0));
endmodule

// File: tb/test_fanout_cfg_ctrl.sv
module test_fanout_cfg_ctrl;
    localparam int N = 10;

    logic         ck = 0, rst_n = 0, en = 0, si = 0, clk_in0 = 1, clk_in1 = 0;
    logic [N-1:0] q_data, q_oe;
    int           checks = 0, errors = 0;
    bit           done = 0;

    fanout_cfg_ctrl #(.NUM_OUT(N)) i_fanout_cfg_ctrl (
        .ck(ck), .rst_n(rst_n), .en(en), .si(si),
        .clk_in0(clk_in0), .clk_in1(clk_in1),
        .q_data(q_data), .q_oe(q_oe)
    );

    always #10 ck = ~ck;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic exp_clk(input string req, input logic sel);
        chk(req, q_data, {N{sel ? clk_in1 : clk_in0}});
    endtask

    // en-low edge clears the loader
    task automatic en_low_clear();
        @(negedge ck); en = 0; si = 0;
        @(negedge ck);
    endtask

    // send a word; enable for output 9 first, select last; stops before the commit edge
    task automatic send_word(input logic [N-1:0] oe_w, input logic sel);
        for (int i = N - 1; i >= 0; i--) begin
            en = 1; si = oe_w[i];
            @(negedge ck);
        end
        si = sel;
        @(negedge ck);
    endtask

    task automatic t_reset();
        en = 1;
        #1;
        chk("R1 oe", q_oe, '0);
        exp_clk("R1 data", 1'b0);
    endtask

    task automatic t_fixed();
        en = 0; si = 0; #1;
        chk("R8 oe", q_oe, '1);
        exp_clk("R8 sel0", 1'b0);
        si = 1; #1;
        exp_clk("R8 sel1", 1'b1);
        clk_in0 = 0; clk_in1 = 1; #1;
        exp_clk("R8 sel1 swapped", 1'b1);
        clk_in0 = 1; clk_in1 = 0;
    endtask

    task automatic t_program(input logic [N-1:0] oe_w, input logic sel);
        en_low_clear();
        send_word(oe_w, sel);
        chk("R2 no effect before commit", q_oe, '0);
        exp_clk("R2 select before commit", 1'b0);
        si = ~sel;
        @(negedge ck);
        chk("R3 R5 enables", q_oe, oe_w);
        exp_clk("R4 select", sel);
        clk_in0 = ~clk_in0; clk_in1 = ~clk_in1; #1;
        exp_clk("R4 follows clock", sel);
        clk_in0 = ~clk_in0; clk_in1 = ~clk_in1;
    endtask

    task automatic t_locked(input logic [N-1:0] oe_w, input logic sel);
        for (int i = 0; i < 15; i++) begin
            si = i[0];
            @(negedge ck);
        end
        chk("R7 oe held", q_oe, oe_w);
        exp_clk("R7 select held", sel);
    endtask

    task automatic t_clear();
        en_low_clear();
        en = 1; #1;
        chk("R6 oe cleared", q_oe, '0);
        exp_clk("R6 select cleared", 1'b0);
    endtask

    task automatic t_abort();
        en_low_clear();
        for (int i = 0; i < 5; i++) begin
            en = 1; si = 1;
            @(negedge ck);
        end
        en_low_clear();
        send_word(10'b0000000001, 1'b0);
        @(negedge ck);
        chk("R9 restart oe", q_oe, 10'b0000000001);
        exp_clk("R9 restart select", 1'b0);
    endtask

    task automatic t_async();
        en_low_clear();
        for (int i = 0; i < 4; i++) begin
            en = 1; si = 1;
            @(negedge ck);
        end
        rst_n = 0; #1; rst_n = 1;
        send_word(10'b1000000000, 1'b1);
        @(negedge ck);
        chk("R1 async restart oe", q_oe, 10'b1000000000);
        exp_clk("R1 async restart select", 1'b1);
    endtask

    initial begin
        rst_n = 0;
        repeat (2) @(negedge ck);
        rst_n = 1;
        t_reset();
        t_fixed();
        t_program(10'b1000000001, 1'b1);
        t_locked(10'b1000000001, 1'b1);
        t_program(10'b0110101100, 1'b0);
        t_locked(10'b0110101100, 1'b0);
        t_program(10'b1111111111, 1'b1);
        t_clear();
        t_abort();
        t_async();
        t_fixed();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge ck);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule